// File: doc/BRIEF.md
# Prescaled Interval Timer Channel

This block is one 16-bit timer channel. A power-of-two prescaler divides the system clock, and each resulting tick moves the count by one. The count can run up or down. It either wraps across the full 16-bit range or wraps at a programmable limit. Three compare values are checked against the count. Six sticky status flags record wraps and compare hits. The flags stay set until a one-cycle clear strobe wipes them.

A counter-control register is written through a write strobe and read back on a port. It holds five stored bits:

| Bit | Function |
|-----|----------|
| 0 | Halt |
| 1 | Limit mode |
| 2 | Down |
| 3 | Compare enable |
| 5 | Spare |

Bit 4 is a command bit and is never stored. Writing it with a 1 zeroes the count on the same clock edge.

The run state is an enumerated mode decoded from the register. The modes are:
- HALT: bit 0 is set.
- UP_FREE: counting up with no limit.
- UP_IVAL: counting up to the limit.
- DN_FREE: counting down with no limit.
- DN_IVAL: counting down from the limit.

A counter write moves the mode from any state to any other. There are two transitions:
- Entering HALT freezes the count and the prescaler.
- Leaving HALT resumes counting with a fresh prescaler phase.

Top module: `ptimer_channel`

## Requirements
- R1: Clock control bit 0 enables the prescaler and bits 4:1 hold N. With the prescaler enabled, the count moves once every 2^(N+1) clocks. With it disabled, the count moves on every clock.
- R2: Counter control bit 0 halts counting, so the count holds. Bit 1 selects limit mode, bit 2 selects counting down and bit 3 enables the compare flags.
- R3: A control write with bit 4 = 1 zeroes the count on that write's clock edge. Bit 4 always reads back as 0, and the other five bits are stored as written.
- R4: After reset, the control readback is 0x21, the count is 0 and the status is 0.
- R5: Counting up in limit mode, the count goes from 0 to the limit value, then returns to 0 and sets status bit 0.
- R6: Counting up in free mode, the count wraps from 0xFFFF to 0 and sets status bit 4.
- R7: Counting down, the count wraps from 0 to the top value. The top value is the limit in limit mode and 0xFFFF in free mode. The wrap sets bit 0 in limit mode and bit 4 in free mode.
- R8: Status bits 1, 2 and 3 set when the count becomes equal to compare value 1, 2 or 3, and only while compare enable is 1. A compare value above the top value never fires.
- R9: Status flags are sticky until the clear strobe, and a flag that sets in the same cycle as the clear stays set. Status bit 5 stays 0.
- R10: The prescaler phase restarts whenever the channel is halted or its count is zeroed by command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_cfg | input | 6 | Prescaler enable (bit 0) and N (bits 4:1) |
| interval | input | 16 | Limit value for limit mode |
| match_val | input | 3x16 | Compare values; element i drives status bit i+1 |
| ctrl_wr | input | 1 | Write strobe for counter control |
| ctrl_wdata | input | 6 | Counter control write data |
| status_clr | input | 1 | Clears all status flags |
| ctrl_rd | output | 6 | Stored counter control |
| count | output | 16 | Current count |
| status | output | 6 | Sticky status flags |

## Verification
The assertions check the following on every cycle:
- the count holds when no tick arrives;
- a zero command leaves a zero count;
- flags never drop without a clear;
- compare flags never appear while compare enable is off;
- a limit-mode wrap flags bit 0;
- enabled prescaler ticks never fall on consecutive clocks.

Exact tick spacing, wrap points in each direction and mode, and compare values above the top value can only be shown by the bench's sweeps. The same holds for the set-beats-clear collision and the prescaler phase restarting after a halt.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
    typedef enum logic [2:0] {
        MODE_HALT,
        MODE_UP_FREE,
        MODE_UP_IVAL,
        MODE_DN_FREE,
        MODE_DN_IVAL
    } mode_e;

    localparam int CTL_W      = 6;
    localparam int CTL_HALT   = 0;
    localparam int CTL_IVAL   = 1;
    localparam int CTL_DOWN   = 2;
    localparam int CTL_CMP    = 3;
    localparam int CTL_ZERO   = 4;
    localparam logic [CTL_W-1:0] CTL_RESET = 6'h21;
endpackage

// File: rtl/ptc_prescaler.sv
module ptc_prescaler #(
    parameter int NSEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic              pre_en,
    input  logic [NSEL_W-1:0] nsel,
    output logic              tick
);
    localparam int PW = (1 << NSEL_W) + 1;

    logic [PW-1:0]     pre_q;
    logic [NSEL_W:0]   shamt;
    logic [PW-1:0]     limit;
    logic              at_limit;

    assign shamt    = {1'b0, nsel} + {{NSEL_W{1'b0}}, 1'b1};
    assign limit    = (PW'(1) << shamt) - PW'(1);
    assign at_limit = (pre_q >= limit);
    assign tick     = run && !restart && (!pre_en || at_limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run || restart || !pre_en) begin
            pre_q <= '0;
        end else if (at_limit) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PW'(1);
        end
    end

    // R1: an enabled prescaler never ticks on two consecutive clocks
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pre_en) |=> (!pre_en || !tick));
endmodule

// File: rtl/ptc_counter.sv
module ptc_counter
    import ptc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  mode_e        mode,
    input  logic [W-1:0] top,
    input  logic         zero_cmd,
    input  logic         tick,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nxt,
    output logic         step,
    output logic         wrap
);
    always_comb begin
        cnt_nxt = cnt_q;
        wrap    = 1'b0;
        unique case (mode)
            MODE_HALT: begin
                cnt_nxt = cnt_q;
            end
            MODE_UP_FREE, MODE_UP_IVAL: begin
                if (cnt_q >= top) begin
                    cnt_nxt = '0;
                    wrap    = 1'b1;
                end else begin
                    cnt_nxt = cnt_q + W'(1);
                end
            end
            MODE_DN_FREE, MODE_DN_IVAL: begin
                if (cnt_q == '0) begin
                    cnt_nxt = top;
                    wrap    = 1'b1;
                end else begin
                    cnt_nxt = cnt_q - W'(1);
                end
            end
            default: cnt_nxt = cnt_q;
        endcase
    end

    assign step = tick && (mode != MODE_HALT) && !zero_cmd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (zero_cmd) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_nxt;
        end
    end

    // R2: without a tick the count holds
    p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !zero_cmd) |=> $stable(cnt_q));
    // R3: a zero command leaves a zero count
    p_zero_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        zero_cmd |=> (cnt_q == '0));
endmodule

// File: rtl/ptc_match.sv
module ptc_match #(
    parameter int W = 16,
    parameter int N = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W-1:0]        cnt_nxt,
    input  logic                step,
    input  logic [W-1:0]        top,
    input  logic                cmp_en,
    input  logic [N-1:0][W-1:0] match_val,
    output logic [N-1:0]        hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        logic in_range;
        assign in_range = (match_val[i] <= top);
        assign hit[i]   = step && cmp_en && in_range && (cnt_nxt == match_val[i]);
    end

    // R8: no compare hit without compare enable
    p_hit_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |-> cmp_en);
endmodule

// File: rtl/ptimer_channel.sv
module ptimer_channel
    import ptc_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int NSEL_W    = 4,
    parameter int NUM_MATCH = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSEL_W+1:0]           clk_cfg,
    input  logic [CNT_W-1:0]            interval,
    input  logic [NUM_MATCH-1:0][CNT_W-1:0] match_val,
    input  logic                        ctrl_wr,
    input  logic [CTL_W-1:0]            ctrl_wdata,
    input  logic                        status_clr,
    output logic [CTL_W-1:0]            ctrl_rd,
    output logic [CNT_W-1:0]            count,
    output logic [NUM_MATCH+2:0]        status
);
    localparam int ST_W   = NUM_MATCH + 3;
    localparam int ST_IV  = 0;
    localparam int ST_OV  = NUM_MATCH + 1;
    localparam logic [CTL_W-1:0] STORE_MASK = ~(CTL_W'(1) << CTL_ZERO);

    logic [CTL_W-1:0] ctrl_q;
    logic             zero_cmd;
    mode_e            mode;
    logic [CNT_W-1:0] top;
    logic             tick;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             step;
    logic             wrap;
    logic [NUM_MATCH-1:0] hit;
    logic [ST_W-1:0]  set_vec;
    logic [ST_W-1:0]  status_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTL_RESET;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_wdata & STORE_MASK;
        end
    end

    assign zero_cmd = ctrl_wr && ctrl_wdata[CTL_ZERO];

    always_comb begin
        if (ctrl_q[CTL_HALT]) begin
            mode = MODE_HALT;
        end else begin
            unique case ({ctrl_q[CTL_DOWN], ctrl_q[CTL_IVAL]})
                2'b00:   mode = MODE_UP_FREE;
                2'b01:   mode = MODE_UP_IVAL;
                2'b10:   mode = MODE_DN_FREE;
                default: mode = MODE_DN_IVAL;
            endcase
        end
    end

    assign top = ctrl_q[CTL_IVAL] ? interval : '1;

    ptc_prescaler #(.NSEL_W(NSEL_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (!ctrl_q[CTL_HALT]),
        .restart (zero_cmd),
        .pre_en  (clk_cfg[0]),
        .nsel    (clk_cfg[NSEL_W:1]),
        .tick    (tick)
    );

    ptc_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .top      (top),
        .zero_cmd (zero_cmd),
        .tick     (tick),
        .cnt_q    (cnt_q),
        .cnt_nxt  (cnt_nxt),
        .step     (step),
        .wrap     (wrap)
    );

    ptc_match #(.W(CNT_W), .N(NUM_MATCH)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_nxt   (cnt_nxt),
        .step      (step),
        .top       (top),
        .cmp_en    (ctrl_q[CTL_CMP]),
        .match_val (match_val),
        .hit       (hit)
    );

    always_comb begin
        set_vec = '0;
        set_vec[NUM_MATCH:1] = hit;
        if (step && wrap) begin
            if (ctrl_q[CTL_IVAL]) set_vec[ST_IV] = 1'b1;
            else                  set_vec[ST_OV] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_clr ? '0 : status_q) | set_vec;
        end
    end

    assign ctrl_rd = ctrl_q;
    assign count   = cnt_q;
    assign status  = status_q;

    // R3: a write stores every bit but the zero command
    p_ctrl_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (ctrl_rd == ($past(ctrl_wdata) & STORE_MASK)));
    // R9: flags never drop without a clear
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !status_clr |=> ((status_q & $past(status_q)) == $past(status_q)));
    // R8: compare flags do not newly appear while compare enable is off
    p_no_cmp_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[CTL_CMP] && !status_clr) |=>
        (status_q[NUM_MATCH:1] == $past(status_q[NUM_MATCH:1])));
    // R5: limit-mode up wrap flags bit 0
    p_ival_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_UP_IVAL && step && cnt_q >= interval) |=> status_q[ST_IV]);
endmodule

// File: tb/ptimer_channel_tb.sv
module ptimer_channel_tb;
    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [5:0]       clk_cfg = '0;
    logic [15:0]      interval = '0;
    logic [2:0][15:0] match_val = '0;
    logic             ctrl_wr = 1'b0;
    logic [5:0]       ctrl_wdata = '0;
    logic             status_clr = 1'b0;
    logic [5:0]       ctrl_rd;
    logic [15:0]      count;
    logic [5:0]       status;

    int n_cmp = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptimer_channel u_dut (
        .clk(clk), .rst_n(rst_n), .clk_cfg(clk_cfg), .interval(interval),
        .match_val(match_val), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .status_clr(status_clr), .ctrl_rd(ctrl_rd), .count(count),
        .status(status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [5:0] v);
        ctrl_wr = 1'b1;
        ctrl_wdata = v;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic pulse_clr();
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
    endtask

    initial begin
        int hold;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4 ctrl", ctrl_rd, 32'h21);
        chk("R4 count", count, 0);
        chk("R4 status", status, 0);

        // Limit mode up, interval 5, compares 2 / 7 / 0
        interval = 16'd5;
        match_val[0] = 16'd2; match_val[1] = 16'd7; match_val[2] = 16'd0;
        wr_ctrl(6'h1A);
        chk("R3 readback", ctrl_rd, 32'h0A);
        chk("R3 zeroed", count, 0);
        for (int k = 1; k <= 14; k++) begin
            @(negedge clk);
            chk("R5 count", count, k % 6);
        end
        chk("R5 R8 flags", status, 32'h0B);
        pulse_clr();
        chk("R9 cleared", status, 0);
        repeat (2) @(negedge clk);
        chk("R5 before wrap", count, 5);
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
        chk("R9 set wins", status, 32'h09);
        wr_ctrl(6'h0B);
        hold = count;
        repeat (5) @(negedge clk);
        chk("R2 halt holds", count, hold);

        // Free mode down
        pulse_clr();
        wr_ctrl(6'h14);
        chk("R3 zeroed dn", count, 0);
        @(negedge clk);
        chk("R7 wrap count", count, 32'hFFFF);
        chk("R7 wrap flag", status, 32'h10);
        repeat (3) @(negedge clk);
        chk("R7 down", count, 32'hFFFC);

        // Free mode up, compare disabled
        match_val[0] = 16'd3;
        wr_ctrl(6'h10);
        pulse_clr();
        chk("R6 start", count, 1);
        repeat (65534) @(negedge clk);
        chk("R6 top", count, 32'hFFFF);
        @(negedge clk);
        chk("R6 wrap count", count, 0);
        chk("R6 R8 flags", status, 32'h10);

        // Prescaler N=2 (period 8)
        wr_ctrl(6'h11);
        clk_cfg = 6'h05;
        pulse_clr();
        wr_ctrl(6'h00);
        for (int m = 1; m <= 43; m++) begin
            @(negedge clk);
            if (m % 8 == 0 || m % 8 == 1)
                chk("R1 tick spacing", count, m / 8);
        end
        wr_ctrl(6'h01);
        repeat (2) @(negedge clk);
        wr_ctrl(6'h00);
        repeat (7) @(negedge clk);
        chk("R10 phase restart early", count, 5);
        @(negedge clk);
        chk("R10 phase restart tick", count, 6);

        // Limit mode down, interval 4, compares 4 / 9 / 1
        clk_cfg = 6'h00;
        wr_ctrl(6'h01);
        interval = 16'd4;
        match_val[0] = 16'd4; match_val[1] = 16'd9; match_val[2] = 16'd1;
        pulse_clr();
        wr_ctrl(6'h1E);
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            chk("R7 limit down", count, (5 - k % 5) % 5);
        end
        chk("R7 R8 flags", status, 32'h0B);
        chk("R9 bit5", status[5], 0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule